// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block collects the interrupt events of a full-speed USB device controller and turns them into one active-high interrupt line. Endpoint events arrive as one-cycle pulses with a 3-bit endpoint number, covering endpoint 0 and four data endpoints. Bus-level events arrive as one-cycle pulses with a 2-bit type code: suspend, resume and bus reset. Software sees four byte-wide registers: the endpoint status, the bus event status, the endpoint enable and the bus event enable.

Enables are applied when an event is recorded, not at the output. Each time any event is recorded, both status registers are ANDed with their enables. A pending bit whose enable is cleared afterwards therefore stays pending, and keeps the line asserted, until the next event arrives or software clears it. The bus event enable always keeps its resume bit set, so resume events cannot be masked. A read of that register hides the resume bit.

The event inputs have no back-pressure. A pulse is taken in the cycle it is valid, and there is no ready signal. The register port is also always ready: a write takes effect at the next clock edge, and read data is combinational from `reg_addr`.

Top module: `usb_irq_ctrl`

## Requirements
- R1: An endpoint event with number n in 0..4 sets bit n of the endpoint status register (address 0, bits 4:0) when endpoint enable bit n is set. Numbers 5..7 change nothing.
- R2: After reset, both status registers read 0x00, the endpoint enable register (address 2) reads 0x1F, the bus event enable register (address 3) reads 0x00 and `irq` is low.
- R3: Writing address 0 or address 1 clears each status bit written as one and keeps the bits written as zero.
- R4: In a cycle that records any event, the endpoint status is ANDed with the endpoint enable and the bus event status is ANDed with the bus event enable. The enable values used are those held before that cycle's write. In a cycle with no event, status bits are not masked, even if their enable is zero.
- R5: A write to address 3 stores bits 0 and 2 of the data and always sets bit 1. A read of address 3 returns the stored value with bit 1 forced to zero, so a resume event is always recorded.
- R6: A bus event sets one bit of the bus event status register (address 1): code 0 (suspend) sets bit 0, code 1 (resume) sets bit 1 and code 2 (bus reset) sets bit 2, each subject to its enable. Code 3 is ignored. No bus event sets an endpoint status bit.
- R7: `irq` is the OR of all endpoint status bits and bus event status bits. It is registered, so it follows a status change one clock later.
- R8: A write to address 2 stores only bits 4:0. Unused read bits of every register return zero.
- R9: When an event and a status-clearing write meet in the same cycle, the event's bit ends up set, and the clear still acts on the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 endpoint status, 1 bus event status, 2 endpoint enable, 3 bus event enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ep_evt_vld | input | 1 | One-cycle endpoint event pulse |
| ep_evt_num | input | 3 | Endpoint number of the event |
| uev_evt_vld | input | 1 | One-cycle bus event pulse |
| uev_evt_code | input | 2 | Bus event type: 0 suspend, 1 resume, 2 bus reset, 3 none |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that every event valid lasts one cycle, and that the number and code inputs matter only while their valid is high. They also assume no input is unknown once reset is released, and that `reg_addr` is settled before a write edge. The bench keeps to these rules by changing inputs only on the falling clock edge and dropping every valid after a single rising edge. Where it needs both an endpoint event and a write in the same cycle, it drives them together inside one step.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int EP_CNT     = 5;
  localparam int UEV_CNT    = 3;
  localparam int UEV_CODE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RSEL_EP_STAT  = 2'd0,
    RSEL_UEV_STAT = 2'd1,
    RSEL_EP_EN    = 2'd2,
    RSEL_UEV_EN   = 2'd3
  } reg_sel_e;

  // bus event enable: bits kept on write, bit forced on write and hidden on read
  localparam logic [UEV_CNT-1:0] UEV_KEEP  = 3'b101;
  localparam logic [UEV_CNT-1:0] UEV_FORCE = 3'b010;
endpackage

// File: rtl/uic_evt_decode.sv
module uic_evt_decode #(
  parameter int CNT   = 5,
  parameter int IDX_W = 3
) (
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  output logic [CNT-1:0]   set_vec
);
  // one comparator per source; indices beyond CNT match nothing
  for (genvar i = 0; i < CNT; i++) begin : g_dec
    assign set_vec[i] = vld && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/uic_stat_bank.sv
module uic_stat_bank #(
  parameter int           W        = 5,
  parameter logic [W-1:0] EN_RST   = '1,
  parameter logic [W-1:0] EN_KEEP  = '1,
  parameter logic [W-1:0] EN_FORCE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic         en_we,
  input  logic [W-1:0] en_data,
  output logic [W-1:0] stat,
  output logic [W-1:0] en
);
  logic [W-1:0] stat_d;

  always_comb begin
    stat_d = stat & ~(clr_we ? clr_data : '0);
    stat_d = stat_d | set_vec;
    if (rec) stat_d = stat_d & en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= EN_RST;
    end else begin
      stat <= stat_d;
      if (en_we) en <= (en_data & EN_KEEP) | EN_FORCE;
    end
  end

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !rec) |=> ((stat & $past(clr_data)) == '0));

  // R4
  mask_on_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> ((stat & ~$past(en)) == '0));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec && !clr_we) |=> (stat == $past(stat)));

  // R9
  merge_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && clr_we) |=> ((stat & $past(set_vec & en)) == $past(set_vec & en)));

  // R5
  en_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((en & EN_FORCE) == EN_FORCE) && ((en & ~(EN_KEEP | EN_FORCE)) == '0)));
endmodule

// File: rtl/uic_irq_reg.sv
module uic_irq_reg #(
  parameter int EP_W  = 5,
  parameter int UEV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EP_W-1:0]  ep_stat,
  input  logic [UEV_W-1:0] uev_stat,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (|ep_stat) | (|uev_stat);
  end

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ep_stat) != '0 || $past(uev_stat) != '0));
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP  = EP_CNT,
  parameter int NUM_UEV = UEV_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ep_evt_vld,
  input  logic [2:0]        ep_evt_num,
  input  logic              uev_evt_vld,
  input  logic [UEV_CODE_W-1:0] uev_evt_code,
  output logic              irq
);
  localparam int EP_NUM_W = 3;

  reg_sel_e            sel;
  logic [NUM_EP-1:0]   ep_set, ep_stat, ep_en;
  logic [NUM_UEV-1:0]  uev_set, uev_stat, uev_en;
  logic                rec;
  logic                unused_wdata_hi;

  assign sel             = reg_sel_e'(reg_addr);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_EP];

  uic_evt_decode #(.CNT(NUM_EP), .IDX_W(EP_NUM_W)) u_ep_dec (
    .vld(ep_evt_vld), .idx(ep_evt_num), .set_vec(ep_set));

  uic_evt_decode #(.CNT(NUM_UEV), .IDX_W(UEV_CODE_W)) u_uev_dec (
    .vld(uev_evt_vld), .idx(uev_evt_code), .set_vec(uev_set));

  assign rec = (|ep_set) | (|uev_set);

  uic_stat_bank #(
    .W(NUM_EP), .EN_RST('1), .EN_KEEP('1), .EN_FORCE('0)
  ) u_ep_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(ep_set), .rec(rec),
    .clr_we(reg_we && sel == RSEL_EP_STAT), .clr_data(reg_wdata[NUM_EP-1:0]),
    .en_we(reg_we && sel == RSEL_EP_EN), .en_data(reg_wdata[NUM_EP-1:0]),
    .stat(ep_stat), .en(ep_en));

  uic_stat_bank #(
    .W(NUM_UEV), .EN_RST(UEV_FORCE), .EN_KEEP(UEV_KEEP), .EN_FORCE(UEV_FORCE)
  ) u_uev_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(uev_set), .rec(rec),
    .clr_we(reg_we && sel == RSEL_UEV_STAT), .clr_data(reg_wdata[NUM_UEV-1:0]),
    .en_we(reg_we && sel == RSEL_UEV_EN), .en_data(reg_wdata[NUM_UEV-1:0]),
    .stat(uev_stat), .en(uev_en));

  uic_irq_reg #(.EP_W(NUM_EP), .UEV_W(NUM_UEV)) u_irq (
    .clk(clk), .rst_n(rst_n), .ep_stat(ep_stat), .uev_stat(uev_stat), .irq(irq));

  always_comb begin
    unique case (sel)
      RSEL_EP_STAT:  reg_rdata = DATA_W'(ep_stat);
      RSEL_UEV_STAT: reg_rdata = DATA_W'(uev_stat);
      RSEL_EP_EN:    reg_rdata = DATA_W'(ep_en);
      default:       reg_rdata = DATA_W'(uev_en & ~UEV_FORCE);
    endcase
  end

  // R1
  oor_ep_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_evt_vld && ep_evt_num >= EP_NUM_W'(NUM_EP) && !uev_evt_vld && !reg_we)
      |=> (ep_stat == $past(ep_stat)));

  // R7
  ep0_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_evt_vld && ep_evt_num == '0 && ep_en[0]) |=> ##1 irq);

  // R6
  bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uev_evt_vld && uev_evt_code == 2'd2 && uev_en[2]) |=> uev_stat[2]);
endmodule

// File: tb/sim_usb_irq_ctrl.sv
module sim_usb_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ep_evt_vld;
  logic [2:0] ep_evt_num;
  logic       uev_evt_vld;
  logic [1:0] uev_evt_code;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  logic [4:0] m_ep_stat, m_ep_en;
  logic [2:0] m_us_stat, m_us_en;
  logic       exp_irq;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_evt_vld(ep_evt_vld),
    .ep_evt_num(ep_evt_num), .uev_evt_vld(uev_evt_vld),
    .uev_evt_code(uev_evt_code), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a;
    #1;
    rv = reg_rdata;
  endtask

  // one clock: drive after a falling edge, update the model, wait for next falling edge
  task automatic step(input bit wr, input logic [1:0] a, input logic [7:0] d,
                      input bit ev, input logic [2:0] n, input bit uv, input logic [1:0] uc);
    logic [4:0] eset;
    logic [2:0] uset;
    logic       pend_old;
    reg_we = wr; reg_addr = a; reg_wdata = d;
    ep_evt_vld = ev; ep_evt_num = n; uev_evt_vld = uv; uev_evt_code = uc;
    eset = (ev && n < 3'd5) ? (5'd1 << n) : 5'd0;
    uset = (uv && uc < 2'd3) ? (3'd1 << uc) : 3'd0;
    pend_old = (m_ep_stat != 0) || (m_us_stat != 0);
    m_ep_stat = (m_ep_stat & ~((wr && a == 2'd0) ? d[4:0] : 5'd0)) | eset;
    m_us_stat = (m_us_stat & ~((wr && a == 2'd1) ? d[2:0] : 3'd0)) | uset;
    if (eset != 0 || uset != 0) begin
      m_ep_stat = m_ep_stat & m_ep_en;
      m_us_stat = m_us_stat & m_us_en;
    end
    if (wr && a == 2'd2) m_ep_en = d[4:0];
    if (wr && a == 2'd3) m_us_en = (d[2:0] & 3'b101) | 3'b010;
    @(negedge clk);
    reg_we = 1'b0; ep_evt_vld = 1'b0; uev_evt_vld = 1'b0;
    exp_irq = pend_old;
    chk("R7 irq follows status one clock later", {7'd0, irq}, {7'd0, exp_irq});
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 3'd0, 1'b0, 2'd0);
  endtask

  task automatic ep_fire(input logic [2:0] n);
    step(1'b0, 2'd0, 8'd0, 1'b1, n, 1'b0, 2'd0);
  endtask

  task automatic uev_fire(input logic [1:0] c);
    step(1'b0, 2'd0, 8'd0, 1'b0, 3'd0, 1'b1, c);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 8'd0, 1'b0, 3'd0, 1'b0, 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
    ep_evt_vld = 1'b0; ep_evt_num = 3'd0; uev_evt_vld = 1'b0; uev_evt_code = 2'd0;
    m_ep_stat = 5'd0; m_ep_en = 5'h1F; m_us_stat = 3'd0; m_us_en = 3'b010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(2'd0); chk("R2 ep status reset", rv, 8'h00);
    rd(2'd1); chk("R2 bus status reset", rv, 8'h00);
    rd(2'd2); chk("R2 ep enable reset", rv, 8'h1F);
    rd(2'd3); chk("R2 bus enable reset", rv, 8'h00);
    chk("R2 irq reset", {7'd0, irq}, 8'h00);

    // R8 ep enable keeps low five bits
    wr_reg(2'd2, 8'hFF); rd(2'd2); chk("R8 ep enable width", rv, 8'h1F);
    wr_reg(2'd2, 8'hE0); rd(2'd2); chk("R8 ep enable width", rv, 8'h00);

    // R1 sweep: every enable pattern, every endpoint number
    for (int en = 0; en < 32; en++) begin
      for (int n = 0; n < 8; n++) begin
        wr_reg(2'd2, 8'(en));
        wr_reg(2'd0, 8'h1F);
        ep_fire(3'(n));
        rd(2'd0);
        chk("R1 ep event sets enabled bit", rv, (n < 5) ? 8'((1 << n) & en) : 8'h00);
      end
    end

    // R5 bus enable write and read-back
    for (int v = 0; v < 256; v++) begin
      wr_reg(2'd3, 8'(v)); rd(2'd3);
      chk("R5 bus enable read-back", rv, 8'(v & 5));
    end

    // R6 bus events under every enable value
    wr_reg(2'd0, 8'h1F);
    for (int v = 0; v < 8; v++) begin
      for (int c = 0; c < 4; c++) begin
        wr_reg(2'd3, 8'(v) | 8'hF8);
        wr_reg(2'd1, 8'h07);
        uev_fire(2'(c));
        rd(2'd1);
        chk("R6 bus event bit", rv, (c < 3) ? 8'((1 << c) & ((v & 5) | 2)) : 8'h00);
        rd(2'd0);
        chk("R6 no ep bit from bus event", rv, 8'h00);
      end
    end

    // R3 write-one-to-clear, all patterns
    wr_reg(2'd2, 8'h1F);
    for (int c = 0; c < 32; c++) begin
      for (int n = 0; n < 5; n++) ep_fire(3'(n));
      wr_reg(2'd0, 8'(c)); rd(2'd0);
      chk("R3 ep status clear", rv, 8'(5'h1F & ~c));
    end
    wr_reg(2'd3, 8'h07);
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 3; k++) uev_fire(2'(k));
      wr_reg(2'd1, 8'(c)); rd(2'd1);
      chk("R3 bus status clear", rv, 8'(3'h7 & ~c));
    end

    // R4 stale bit survives until the next event masks it
    wr_reg(2'd0, 8'h1F); wr_reg(2'd1, 8'h07);
    ep_fire(3'd1);
    wr_reg(2'd2, 8'h1D);
    idle(); idle();
    rd(2'd0); chk("R4 no event, no masking", rv, 8'h02);
    chk("R4 stale bit keeps irq", {7'd0, irq}, 8'h01);
    ep_fire(3'd3);
    rd(2'd0); chk("R4 event masks stale bit", rv, 8'h08);
    wr_reg(2'd3, 8'h00);
    uev_fire(2'd1);
    rd(2'd1); chk("R4 resume kept by forced enable", rv, 8'h02);

    // R9 event and clear in the same cycle
    wr_reg(2'd2, 8'h1F); wr_reg(2'd1, 8'h07);
    ep_fire(3'd0); ep_fire(3'd1);
    step(1'b1, 2'd0, 8'h1F, 1'b1, 3'd2, 1'b0, 2'd0);
    rd(2'd0); chk("R9 ep event wins over clear", rv, 8'h04);
    wr_reg(2'd3, 8'h05);
    uev_fire(2'd0);
    step(1'b1, 2'd1, 8'h07, 1'b0, 3'd0, 1'b1, 2'd2);
    rd(2'd1); chk("R9 bus event wins over clear", rv, 8'h04);

    // R7 explicit timing
    wr_reg(2'd0, 8'h1F); wr_reg(2'd1, 8'h07); idle();
    chk("R7 irq low when idle", {7'd0, irq}, 8'h00);
    ep_fire(3'd0);
    chk("R7 irq not yet high", {7'd0, irq}, 8'h00);
    idle();
    chk("R7 irq high one clock later", {7'd0, irq}, 8'h01);
    wr_reg(2'd0, 8'h01);
    chk("R7 irq holds through clear edge", {7'd0, irq}, 8'h01);
    idle();
    chk("R7 irq drops one clock after clear", {7'd0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule